// File: doc/BRIEF.md
# Host Parallel Port Bus Bridge

This block sits between a host processor's narrow parallel port and a 16-bit asynchronous CPU bus with a 24-bit address. The host has a 16-bit data path, a 2-bit register select, and separate active-low read and write strobes. Through these it loads a small register set and starts bus cycles. It then polls a busy output and collects the returned data.

A single write to the high-address register does three things. It supplies address bits 23:16 and carries the access size and direction in its upper byte. It also starts the bus cycle, which can be a byte or word access and a read or a write. A status register reports the target's interrupt level. It also holds an init bit that parks the transaction engine, and writing its pulse bit asserts a timed reset on the target bus. The target side is a plain strobe/acknowledge handshake.

Host strobes arrive asynchronously. Each write strobe passes through a synchronizer, and the write takes effect when the strobe is released. The host must hold select and data stable for that window.

Top module: `hpb_bridge`

## Requirements
- R1: After reset, hp_busy is 0, bus_as_n, bus_uds_n and bus_lds_n are 1, bus_reset is 0, and hp_doe is 0.
- R2: The register select codes are 0 = DATA, 1 = ADDR_LO, 2 = ADDR_HI and 3 = STATUS. A host write takes effect after hp_wr_n is released. A read of ADDR_LO returns the last value written to it. A read of ADDR_HI returns the access code in bits 9:8 and address bits 23:16 in bits 7:0.
- R3: Writing ADDR_HI starts a bus cycle at address {ADDR_HI[7:0], ADDR_LO}. Bits 9:8 of that write select the access: 0 = word write, 1 = byte write, 2 = word read, 3 = byte read. bus_rw is 1 for reads.
- R4: On a write access, bus_wdata carries the DATA register value held at the moment the cycle started.
- R5: hp_busy rises when a cycle starts. bus_as_n stays low until bus_dtack_n is sampled low, and it is released on the next clock. hp_busy falls one clock after bus_as_n is released.
- R6: Lane strobes follow the access type. A word access asserts both bus_uds_n and bus_lds_n. A byte access at an even address (bit 0 = 0) asserts only bus_uds_n. A byte access at an odd address asserts only bus_lds_n. No lane strobe is asserted without bus_as_n.
- R7: A read of DATA returns the word captured when the acknowledge arrived. For a byte read, the selected lane (15:8 at an even address, 7:0 at an odd address) is copied into both halves.
- R8: hp_doe is high only while hp_rd_n is low. hp_dout is 0 whenever hp_doe is low.
- R9: A read of STATUS returns the synchronized bus_ipl in bits 15:13 and the init bit in bit 0. hp_ipl_zero is high exactly when the synchronized level is 0.
- R10: An ADDR_HI write that arrives while hp_busy is high is ignored. No new cycle starts, and ADDR_HI reads back its earlier value.
- R11: Writing STATUS with bit 0 set ends any cycle in progress: hp_busy goes low and the strobes are released. While bit 0 stays set, ADDR_HI writes are ignored. Writing bit 0 as 0 restores normal operation.
- R12: Writing STATUS with bit 1 set drives bus_reset high for exactly RST_LEN clocks (default 16).
- R13: While a cycle is in progress, bus_addr stays equal to the address captured at its start, even if the host writes ADDR_LO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hp_sel | input | 2 | Host register select |
| hp_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| hp_rd_n | input | 1 | Host read strobe, active low |
| hp_din | input | 16 | Host write data |
| hp_dout | output | 16 | Host read data |
| hp_doe | output | 1 | Host data output enable |
| hp_busy | output | 1 | Bus cycle in progress |
| hp_ipl_zero | output | 1 | Target interrupt level is zero |
| bus_addr | output | 24 | Target bus address |
| bus_rw | output | 1 | Target bus direction, 1 = read |
| bus_as_n | output | 1 | Target address strobe, active low |
| bus_uds_n | output | 1 | Upper lane strobe, active low |
| bus_lds_n | output | 1 | Lower lane strobe, active low |
| bus_wdata | output | 16 | Target write data |
| bus_rdata | input | 16 | Target read data |
| bus_dtack_n | input | 1 | Target data acknowledge, active low |
| bus_ipl | input | 3 | Target interrupt level |
| bus_reset | output | 1 | Reset pulse to the target bus |

## Verification
A transaction engine stuck outside idle shows at once as hp_busy never falling. A start decision taken wrongly is equally visible: either a second address strobe appears during a busy-time ADDR_HI write, or no strobe follows a legal one. An error in the captured address, access code or lane selection shows on bus_addr, bus_rw and the lane strobes in the first clock of the cycle. Faults in read steering or the readback multiplexer show only when the host next reads DATA, ADDR_HI or STATUS, a few clocks after the cycle ends.

// File: rtl/hpb_pkg.sv
package hpb_pkg;

   // host register select codes
   typedef enum logic [1:0] {
      SEL_DATA = 2'd0,
      SEL_ALO  = 2'd1,
      SEL_AHI  = 2'd2,
      SEL_STAT = 2'd3
   } hpb_sel_e;

   // access code carried just above the high address bits
   typedef enum logic [1:0] {
      ACC_WR_W = 2'd0,
      ACC_WR_B = 2'd1,
      ACC_RD_W = 2'd2,
      ACC_RD_B = 2'd3
   } hpb_acc_e;

   localparam int ACC_BYTE_BIT = 0;
   localparam int ACC_READ_BIT = 1;

   localparam int STAT_INIT_BIT  = 0;
   localparam int STAT_PULSE_BIT = 1;

   typedef enum logic [1:0] {
      CYC_IDLE  = 2'd0,
      CYC_DRIVE = 2'd1,
      CYC_DROP  = 2'd2
   } hpb_cyc_e;

endpackage

// File: rtl/hpb_sync.sv
module hpb_sync #(
   parameter int           W       = 1,
   parameter int           STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hpb_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("hpb_sync: W must be positive");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= {STAGES{RST_VAL}};
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) begin
            chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/hpb_regs.sv
module hpb_regs
   import hpb_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int ADDR_W  = 24,
   parameter int IPL_W   = 3,
   parameter int RST_LEN = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_commit,
   input  logic [1:0]                 wr_sel,
   input  logic [1:0]                 rd_sel,
   input  logic [DATA_W-1:0]          din,
   input  logic                       busy,
   input  logic [IPL_W-1:0]           ipl_s,
   input  logic [DATA_W-1:0]          cyc_rdata,
   output logic [DATA_W-1:0]          data_q,
   output logic                       launch,
   output logic [ADDR_W-1:0]          launch_addr,
   output logic [1:0]                 launch_acc,
   output logic                       init_on,
   output logic                       pulse_out,
   output logic [DATA_W-1:0]          rd_word
);

   localparam int HI_W = ADDR_W - DATA_W;
   localparam int CW   = $clog2(RST_LEN + 1);

   generate
      if (HI_W < 1 || HI_W + 2 > DATA_W) begin : g_bad_hi
         $error("hpb_regs: high address plus access code must fit one data word");
      end
      if (IPL_W + 2 > DATA_W) begin : g_bad_ipl
         $error("hpb_regs: interrupt level field too wide");
      end
      if (RST_LEN < 1) begin : g_bad_len
         $error("hpb_regs: RST_LEN must be positive");
      end
   endgenerate

   logic [DATA_W-1:0] alo_q;
   logic [HI_W-1:0]   ahi_q;
   logic [1:0]        acc_q;
   logic [CW-1:0]     pulse_cnt;
   logic              ahi_ok;
   logic              stat_wr;

   // R10/R11: high-address stores only while idle and not parked
   assign ahi_ok  = !busy && !init_on;
   assign launch  = wr_commit && (hpb_sel_e'(wr_sel) == SEL_AHI) && ahi_ok;
   assign stat_wr = wr_commit && (hpb_sel_e'(wr_sel) == SEL_STAT);

   assign launch_addr = {din[HI_W-1:0], alo_q};
   assign launch_acc  = din[HI_W+1:HI_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q  <= '0;
         alo_q   <= '0;
         ahi_q   <= '0;
         acc_q   <= ACC_WR_W;
         init_on <= 1'b0;
      end else if (wr_commit) begin
         unique case (hpb_sel_e'(wr_sel))
            SEL_DATA: data_q <= din;
            SEL_ALO:  alo_q  <= din;
            SEL_AHI: begin
               if (ahi_ok) begin
                  ahi_q <= din[HI_W-1:0];
                  acc_q <= din[HI_W+1:HI_W];
               end
            end
            SEL_STAT: init_on <= din[STAT_INIT_BIT];
            default: ;
         endcase
      end
   end

   // R12: timed reset pulse
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse_cnt <= '0;
      end else if (stat_wr && din[STAT_PULSE_BIT]) begin
         pulse_cnt <= CW'(RST_LEN);
      end else if (pulse_cnt != '0) begin
         pulse_cnt <= pulse_cnt - 1'b1;
      end
   end

   assign pulse_out = (pulse_cnt != '0);

   // R2/R7/R9: readback multiplexer
   always_comb begin
      rd_word = '0;
      unique case (hpb_sel_e'(rd_sel))
         SEL_DATA: rd_word = cyc_rdata;
         SEL_ALO:  rd_word = alo_q;
         SEL_AHI: begin
            rd_word[HI_W-1:0]    = ahi_q;
            rd_word[HI_W+1:HI_W] = acc_q;
         end
         SEL_STAT: begin
            rd_word[DATA_W-1 -: IPL_W] = ipl_s;
            rd_word[STAT_INIT_BIT]     = init_on;
         end
         default: rd_word = '0;
      endcase
   end

endmodule

// File: rtl/hpb_cycle.sv
module hpb_cycle
   import hpb_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 24,
   parameter bit LANE_REPL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic              abort,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] wdata_in,
   input  logic [1:0]        acc_in,
   input  logic              dtack_n,
   input  logic [DATA_W-1:0] rdata_in,
   output logic              busy,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   output logic              bus_rw,
   output logic              as_n,
   output logic              uds_n,
   output logic              lds_n,
   output logic [DATA_W-1:0] rdata_q
);

   localparam int LANE_W = DATA_W / 2;

   generate
      if (DATA_W != 2 * LANE_W) begin : g_bad_lanes
         $error("hpb_cycle: DATA_W must split into two equal lanes");
      end
   endgenerate

   hpb_cyc_e          st;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [1:0]        acc_q;
   logic [DATA_W-1:0] rd_steered;
   logic              driving;
   logic              is_byte;

   assign is_byte = acc_q[ACC_BYTE_BIT];

   // R7: lane handling of returned data, variant chosen by parameter
   generate
      if (LANE_REPL) begin : g_repl
         always_comb begin
            if (!is_byte)
               rd_steered = rdata_in;
            else if (addr_q[0])
               rd_steered = {2{rdata_in[LANE_W-1:0]}};
            else
               rd_steered = {2{rdata_in[DATA_W-1:LANE_W]}};
         end
      end else begin : g_pass
         assign rd_steered = rdata_in;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= CYC_IDLE;
         addr_q  <= '0;
         wdata_q <= '0;
         acc_q   <= ACC_WR_W;
         rdata_q <= '0;
      end else if (abort) begin
         st <= CYC_IDLE;                       // R11
      end else begin
         unique case (st)
            CYC_IDLE: begin
               if (launch) begin
                  st      <= CYC_DRIVE;        // R3/R13 capture
                  addr_q  <= addr_in;
                  wdata_q <= wdata_in;
                  acc_q   <= acc_in;
               end
            end
            CYC_DRIVE: begin
               if (!dtack_n) begin
                  st <= CYC_DROP;              // R5
                  if (acc_q[ACC_READ_BIT]) rdata_q <= rd_steered;
               end
            end
            CYC_DROP: st <= CYC_IDLE;
            default:  st <= CYC_IDLE;
         endcase
      end
   end

   assign driving   = (st == CYC_DRIVE);
   assign busy      = (st != CYC_IDLE);
   assign as_n      = !driving;
   // R6: lane strobes
   assign uds_n     = !(driving && (!is_byte || !addr_q[0]));
   assign lds_n     = !(driving && (!is_byte ||  addr_q[0]));
   assign bus_rw    = acc_q[ACC_READ_BIT];
   assign bus_addr  = addr_q;
   assign bus_wdata = wdata_q;

endmodule

// File: rtl/hpb_bridge.sv
module hpb_bridge
   import hpb_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int ADDR_W      = 24,
   parameter int IPL_W       = 3,
   parameter int SYNC_STAGES = 2,
   parameter int RST_LEN     = 16,
   parameter bit LANE_REPL   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        hp_sel,
   input  logic              hp_wr_n,
   input  logic              hp_rd_n,
   input  logic [DATA_W-1:0] hp_din,
   output logic [DATA_W-1:0] hp_dout,
   output logic              hp_doe,
   output logic              hp_busy,
   output logic              hp_ipl_zero,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_rw,
   output logic              bus_as_n,
   output logic              bus_uds_n,
   output logic              bus_lds_n,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_dtack_n,
   input  logic [IPL_W-1:0]  bus_ipl,
   output logic              bus_reset
);

   logic              wr_s;
   logic              wr_prev;
   logic              wr_commit;
   logic [IPL_W-1:0]  ipl_s;
   logic [DATA_W-1:0] data_q;
   logic              launch;
   logic [ADDR_W-1:0] launch_addr;
   logic [1:0]        launch_acc;
   logic              init_on;
   logic [DATA_W-1:0] rd_word;
   logic [DATA_W-1:0] cyc_rdata;

   hpb_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_wr_sync (
      .clk(clk), .rst_n(rst_n), .d(hp_wr_n), .q(wr_s)
   );

   hpb_sync #(.W(IPL_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_ipl_sync (
      .clk(clk), .rst_n(rst_n), .d(bus_ipl), .q(ipl_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_prev <= 1'b1;
      else        wr_prev <= wr_s;
   end

   // R2: commit on the released (rising) write strobe
   assign wr_commit = wr_s && !wr_prev;

   hpb_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IPL_W(IPL_W), .RST_LEN(RST_LEN)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_commit(wr_commit), .wr_sel(hp_sel), .rd_sel(hp_sel),
      .din(hp_din), .busy(hp_busy), .ipl_s(ipl_s), .cyc_rdata(cyc_rdata),
      .data_q(data_q), .launch(launch), .launch_addr(launch_addr),
      .launch_acc(launch_acc), .init_on(init_on), .pulse_out(bus_reset),
      .rd_word(rd_word)
   );

   hpb_cycle #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANE_REPL(LANE_REPL)
   ) u_cycle (
      .clk(clk), .rst_n(rst_n),
      .launch(launch), .abort(init_on),
      .addr_in(launch_addr), .wdata_in(data_q), .acc_in(launch_acc),
      .dtack_n(bus_dtack_n), .rdata_in(bus_rdata),
      .busy(hp_busy), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rw(bus_rw), .as_n(bus_as_n), .uds_n(bus_uds_n), .lds_n(bus_lds_n),
      .rdata_q(cyc_rdata)
   );

   // R8: drive host data only during a read strobe
   assign hp_doe      = !hp_rd_n;
   assign hp_dout     = hp_doe ? rd_word : '0;
   // R9
   assign hp_ipl_zero = (ipl_s == '0);

endmodule

// File: rtl/hpb_bridge_chk.sv
module hpb_bridge_chk #(
   parameter int ADDR_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_as_n,
   input logic              bus_uds_n,
   input logic              bus_lds_n,
   input logic              bus_dtack_n,
   input logic              hp_busy,
   input logic              init_on,
   input logic [ADDR_W-1:0] bus_addr
);

   a_r5_strobe_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_as_n |-> hp_busy);

   a_r5_release_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_as_n && !bus_dtack_n) |=> bus_as_n);

   a_r6_lane_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_as_n |-> (!bus_uds_n || !bus_lds_n));

   a_r6_no_stray_lane: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_uds_n || !bus_lds_n) |-> !bus_as_n);

   a_r11_init_parks: assert property (@(posedge clk) disable iff (!rst_n)
      init_on |=> !hp_busy);

   a_r13_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_as_n && $past(!bus_as_n)) |-> $stable(bus_addr));

endmodule

bind hpb_bridge hpb_bridge_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .bus_as_n(bus_as_n), .bus_uds_n(bus_uds_n), .bus_lds_n(bus_lds_n),
   .bus_dtack_n(bus_dtack_n), .hp_busy(hp_busy), .init_on(init_on),
   .bus_addr(bus_addr)
);

// File: tb/hpb_bridge_test.sv
module hpb_bridge_test;
   import hpb_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int RST_LEN    = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  hp_sel = 2'd0;
   logic        hp_wr_n = 1'b1;
   logic        hp_rd_n = 1'b1;
   logic [15:0] hp_din = '0;
   logic [15:0] hp_dout;
   logic        hp_doe;
   logic        hp_busy;
   logic        hp_ipl_zero;
   logic [23:0] bus_addr;
   logic        bus_rw;
   logic        bus_as_n;
   logic        bus_uds_n;
   logic        bus_lds_n;
   logic [15:0] bus_wdata;
   logic [15:0] bus_rdata = '0;
   logic        bus_dtack_n = 1'b1;
   logic [2:0]  bus_ipl = 3'd0;
   logic        bus_reset;

   always #(CLK_PERIOD/2) clk = ~clk;

   hpb_bridge uut (
      .clk(clk), .rst_n(rst_n), .hp_sel(hp_sel), .hp_wr_n(hp_wr_n),
      .hp_rd_n(hp_rd_n), .hp_din(hp_din), .hp_dout(hp_dout), .hp_doe(hp_doe),
      .hp_busy(hp_busy), .hp_ipl_zero(hp_ipl_zero), .bus_addr(bus_addr),
      .bus_rw(bus_rw), .bus_as_n(bus_as_n), .bus_uds_n(bus_uds_n),
      .bus_lds_n(bus_lds_n), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_dtack_n(bus_dtack_n), .bus_ipl(bus_ipl), .bus_reset(bus_reset)
   );

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   // target model state and observations
   int          tgt_lat = 0;
   int          lat_cnt = 0;
   int          launches = 0;
   int          as_low = 0;
   int          rst_hi = 0;
   logic        as_prev = 1'b1;
   logic        rel_pend = 1'b0;
   logic        rel_busy = 1'b0;
   logic        after_busy = 1'b1;
   logic [23:0] obs_addr = '0;
   logic        obs_rw = 1'b0;
   logic        obs_uds = 1'b1;
   logic        obs_lds = 1'b1;
   logic [15:0] obs_wdata = '0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic logic exp_uds(input logic [1:0] k, input logic [23:0] a);
      return !(k[0] == 1'b0 || a[0] == 1'b0);
   endfunction

   function automatic logic exp_lds(input logic [1:0] k, input logic [23:0] a);
      return !(k[0] == 1'b0 || a[0] == 1'b1);
   endfunction

   function automatic logic [15:0] exp_rd(input logic [1:0] k, input logic [23:0] a,
                                          input logic [15:0] w);
      if (k[0] == 1'b0) return w;
      if (a[0])         return {w[7:0], w[7:0]};
      return {w[15:8], w[15:8]};
   endfunction

   // target bus model, acting away from the active edge
   initial begin
      forever begin
         @(negedge clk);
         if (!bus_as_n) begin
            if (as_prev) begin
               launches++;
               obs_addr  = bus_addr;
               obs_rw    = bus_rw;
               obs_uds   = bus_uds_n;
               obs_lds   = bus_lds_n;
               obs_wdata = bus_wdata;
               lat_cnt   = 0;
               as_low    = 0;
            end
            as_low++;
            if (lat_cnt >= tgt_lat) bus_dtack_n = 1'b0;
            else lat_cnt++;
         end else begin
            bus_dtack_n = 1'b1;
         end
         if (bus_as_n && !as_prev) begin
            rel_busy = hp_busy;
            rel_pend = 1'b1;
         end else if (rel_pend) begin
            after_busy = hp_busy;
            rel_pend   = 1'b0;
         end
         as_prev = bus_as_n;
         if (bus_reset) rst_hi++;
      end
   end

   task automatic host_wr(input logic [1:0] s, input logic [15:0] d);
      @(negedge clk);
      hp_sel  = s;
      hp_din  = d;
      hp_wr_n = 1'b0;
      repeat (3) @(negedge clk);
      hp_wr_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic host_rd(input logic [1:0] s, output logic [15:0] v);
      @(negedge clk);
      hp_sel  = s;
      hp_rd_n = 1'b0;
      @(negedge clk);
      v = hp_dout;
      chk("R8 doe during read", 32'(hp_doe), 32'd1);
      hp_rd_n = 1'b1;
   endtask

   task automatic wait_idle();
      int n = 0;
      while (hp_busy && n < 3000) begin
         @(negedge clk);
         n++;
      end
      if (n >= 3000) chk("R5 busy never cleared", 32'd1, 32'd0);
   endtask

   task automatic do_txn(input logic [1:0] k, input logic [23:0] a,
                         input logic [15:0] wd, input int lat);
      int          l0;
      logic [15:0] v;
      l0      = launches;
      tgt_lat = lat;
      if (!k[1]) host_wr(SEL_DATA, wd);
      host_wr(SEL_ALO, a[15:0]);
      host_wr(SEL_AHI, {6'b0, k, a[23:16]});
      wait_idle();
      chk("R3 one cycle started", 32'(launches), 32'(l0 + 1));
      chk("R3 address", 32'(obs_addr), 32'(a));
      chk("R3 direction", 32'(obs_rw), 32'(k[1]));
      chk("R6 upper strobe", 32'(obs_uds), 32'(exp_uds(k, a)));
      chk("R6 lower strobe", 32'(obs_lds), 32'(exp_lds(k, a)));
      if (!k[1]) begin
         chk("R4 write data", 32'(obs_wdata), 32'(wd));
      end else begin
         host_rd(SEL_DATA, v);
         chk("R7 read data", 32'(v), 32'(exp_rd(k, a, bus_rdata)));
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      int          l0;
      void'($urandom(32'd7041));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 busy", 32'(hp_busy), 32'd0);
      chk("R1 as_n", 32'(bus_as_n), 32'd1);
      chk("R1 uds_n", 32'(bus_uds_n), 32'd1);
      chk("R1 lds_n", 32'(bus_lds_n), 32'd1);
      chk("R1 bus_reset", 32'(bus_reset), 32'd0);
      chk("R1 doe", 32'(hp_doe), 32'd0);

      // R8 idle data bus
      chk("R8 doe idle", 32'(hp_doe), 32'd0);
      chk("R8 dout idle", 32'(hp_dout), 32'd0);

      // R2 decode and readback
      host_wr(SEL_ALO, 16'h1234);
      host_rd(SEL_ALO, v);
      chk("R2 ADDR_LO readback", 32'(v), 32'h1234);

      // R5 timing, word read, latency 5
      bus_rdata = 16'hC3A5;
      do_txn(ACC_RD_W, 24'h0A0010, 16'h0, 5);
      chk("R5 strobe length", 32'(as_low), 32'd6);
      chk("R5 busy at release", 32'(rel_busy), 32'd1);
      chk("R5 busy after release", 32'(after_busy), 32'd0);
      host_rd(SEL_AHI, v);
      chk("R2 ADDR_HI readback", 32'(v), 32'h020A);

      // R7 byte reads at both parities
      bus_rdata = 16'hBEEF;
      do_txn(ACC_RD_B, 24'h000100, 16'h0, 1);
      do_txn(ACC_RD_B, 24'h000101, 16'h0, 0);
      // R4/R6 byte writes
      do_txn(ACC_WR_B, 24'h123456, 16'h7777, 2);
      do_txn(ACC_WR_B, 24'h123457, 16'h0042, 2);

      // R10 and R13: writes during a long cycle
      tgt_lat = 60;
      l0 = launches;
      host_wr(SEL_ALO, 16'h0100);
      host_wr(SEL_AHI, 16'h0212);
      chk("R10 busy after start", 32'(hp_busy), 32'd1);
      host_wr(SEL_AHI, 16'h0034);
      host_wr(SEL_ALO, 16'hBEEF);
      chk("R13 address held", 32'(bus_addr), 32'h120100);
      chk("R13 strobe still low", 32'(bus_as_n), 32'd0);
      wait_idle();
      chk("R10 no second cycle", 32'(launches), 32'(l0 + 1));
      host_rd(SEL_AHI, v);
      chk("R10 ADDR_HI unchanged", 32'(v), 32'h0212);
      host_rd(SEL_ALO, v);
      chk("R2 ADDR_LO during busy", 32'(v), 32'hBEEF);

      // R11 init parks the engine
      tgt_lat = 60;
      host_wr(SEL_ALO, 16'h0002);
      host_wr(SEL_AHI, 16'h0000);
      chk("R11 busy before init", 32'(hp_busy), 32'd1);
      host_wr(SEL_STAT, 16'h0001);
      chk("R11 busy forced low", 32'(hp_busy), 32'd0);
      chk("R11 strobe released", 32'(bus_as_n), 32'd1);
      host_rd(SEL_STAT, v);
      chk("R11 init bit", 32'(v), 32'h0001);
      l0 = launches;
      host_wr(SEL_AHI, 16'h0255);
      chk("R11 no start while parked", 32'(hp_busy), 32'd0);
      chk("R11 no strobe while parked", 32'(launches), 32'(l0));
      host_rd(SEL_AHI, v);
      chk("R11 ADDR_HI unchanged", 32'(v), 32'h0000);
      host_wr(SEL_STAT, 16'h0000);
      do_txn(ACC_WR_W, 24'h00F00E, 16'h55AA, 1);

      // R12 reset pulse
      rst_hi = 0;
      host_wr(SEL_STAT, 16'h0002);
      repeat (30) @(negedge clk);
      chk("R12 pulse length", 32'(rst_hi), 32'(RST_LEN));

      // R9 interrupt level
      bus_ipl = 3'd5;
      repeat (4) @(negedge clk);
      chk("R9 ipl_zero low", 32'(hp_ipl_zero), 32'd0);
      host_rd(SEL_STAT, v);
      chk("R9 status level", 32'(v), 32'hA000);
      bus_ipl = 3'd0;
      repeat (4) @(negedge clk);
      chk("R9 ipl_zero high", 32'(hp_ipl_zero), 32'd1);
      host_rd(SEL_STAT, v);
      chk("R9 status zero", 32'(v), 32'h0000);

      // random mix
      for (int i = 0; i < 40; i++) begin
         logic [1:0]  k;
         logic [23:0] a;
         logic [15:0] wd;
         k  = 2'($urandom_range(0, 3));
         a  = 24'($urandom);
         wd = 16'($urandom);
         if (k == ACC_WR_B && !a[0]) wd = {wd[7:0], wd[7:0]};
         bus_rdata = 16'($urandom);
         do_txn(k, a, wd, int'($urandom_range(0, 7)));
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule